// File: doc/BRIEF.md
# Display Controller Power-On Initializer

This block brings a character display controller into a known state after power-up or after a hardware reset. It holds the controller busy for a fixed hold time of 40 ms, counted in cycles of a clock whose frequency is a parameter. It also walks a blanking pass over display memory and applies the default settings one after another. The defaults cover the display, cursor and blink flags, the entry direction and shift, the bus width, the line count, the extended-mode flag, the bias source and the common/segment scan directions. The configuration registers live here, so the same outputs carry the values that later host instructions set.

Host instructions arrive on a valid/ready stream. An instruction transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole initialization, and a host that keeps `cmd_valid` high must hold `cmd_code` steady until the transfer happens. When power-good is low, everything is cleared. When only the hardware reset pin is pulsed, the configuration keeps its values until each one is overwritten at its own step of the sequence.

Top module: `lcd_por_seq`

## Requirements
- R1: While `pwr_good` is low or `hw_rst_n` is low, `busy` is 1 and `cmd_ready` is 0.
- R2: After both inputs are high, `busy` stays 1 for at least HOLD_CYC = (CLK_HZ/1000)*HOLD_MS clock cycles and falls no later than HOLD_CYC+4 cycles; `cmd_ready` equals the inverse of `busy`.
- R3: A low pulse on `hw_rst_n` during the sequence restarts the hold count from the new release.
- R4: The first step of the sequence pulses `clr_we` for exactly RAM_DEPTH consecutive cycles, with `clr_addr` running 0 to RAM_DEPTH-1 in ascending order and `clr_data` = 0x20. The blanking step also sets `entry_inc` to 1.
- R5: After blanking, the effects land in strictly later cycles, in this order: bus width and line count, display/cursor/blink flags, entry mode, bias source, scan directions.
- R6: When `busy` falls, the outputs are: `bus_8bit`=1, `two_line`=1, `ext_mode`=0, display, cursor and blink off, `entry_inc`=1, `entry_shift`=0, `bias_sel`=00, `com_rev`=00, `seg_rev`=00.
- R7: `pwr_good` low clears every configuration output to 0. A `hw_rst_n` pulse on its own leaves the configuration unchanged until the sequence overwrites it.
- R8: Instructions presented while `busy` is 1 are not taken and change no configuration output.
- R9: When idle, these codes take effect:
  - `001 a b c xx` sets `bus_8bit`=a, `two_line`=b and `ext_mode`=c.
  - `00001 d e f` sets the display, cursor and blink flags to d, e and f.
- R10: The mode-dependent codes are gated by `ext_mode`; any code that decodes to nothing changes nothing.
  - With `ext_mode`=0, `000001 i s` sets `entry_inc`=i and `entry_shift`=s.
  - With `ext_mode`=1, `0001 p q xx` sets `bias_sel`={p,q}.
  - With `ext_mode`=1, `0100 c1 c2 s1 s2` sets `com_rev`={c1,c2} and `seg_rev`={s1,s2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply-good indication; low clears everything |
| hw_rst_n | input | 1 | Active-low hardware reset; restarts the sequence |
| cmd_valid | input | 1 | Host instruction valid |
| cmd_ready | output | 1 | Instruction accepted when high together with valid |
| cmd_code | input | 8 | Host instruction code |
| busy | output | 1 | High while initialization runs |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| entry_inc | output | 1 | Address moves up (1) or down (0) |
| entry_shift | output | 1 | Whole-display shift on write |
| bus_8bit | output | 1 | 8-bit (1) or 4-bit (0) host bus |
| two_line | output | 1 | Two-line (1) or one-line (0) display |
| ext_mode | output | 1 | Extended instruction group selected |
| bias_sel | output | 2 | Bias resistor source, 00 = external |
| com_rev | output | 2 | Common scan reversal, two halves |
| seg_rev | output | 2 | Segment scan reversal, two halves |
| clr_we | output | 1 | Display memory blanking write strobe |
| clr_addr | output | ADDR_W | Blanking write address |
| clr_data | output | 8 | Blanking write data (space code) |

## Verification
A sequencer step and a host write could in principle both update the configuration registers in the same cycle. The bench provokes this by presenting a display-on code for several cycles in the middle of a hardware-reset sequence. It then judges the result by checking that `cmd_ready` stayed low and that the configuration settles exactly on the defaults. A restart pulse and the running hold count also meet within one window. The bench pulses `hw_rst_n` deep into the hold time and measures when `busy` falls, counting from the second release.

// File: rtl/lcd_por_pkg.sv
package lcd_por_pkg;

  typedef enum logic [3:0] {
    ST_START,
    ST_CLEAR,
    ST_FUNC,
    ST_DISP,
    ST_ENTRY,
    ST_BIAS,
    ST_DIR,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic       disp_on;
    logic       cursor_on;
    logic       blink_on;
    logic       entry_inc;
    logic       entry_shift;
    logic       bus_8bit;
    logic       two_line;
    logic       ext_mode;
    logic [1:0] bias_sel;
    logic [1:0] com_rev;
    logic [1:0] seg_rev;
  } cfg_t;

  typedef struct packed {
    logic func;
    logic disp;
    logic entry;
    logic bias;
    logic dir;
  } cmd_hit_t;

  localparam logic [7:0] BLANK_CODE = 8'h20;

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/lcd_por_fsm.sv
module lcd_por_fsm
  import lcd_por_pkg::*;
#(
  parameter int HOLD_CYC  = 2000000,
  parameter int RAM_DEPTH = 80,
  localparam int ADDR_W   = $clog2(RAM_DEPTH),
  localparam int TMR_W    = $clog2(HOLD_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output seq_state_e        state,
  output logic [ADDR_W-1:0] addr,
  output logic              busy
);
  localparam logic [TMR_W-1:0]  HOLD_LIM = TMR_W'(HOLD_CYC);
  localparam logic [ADDR_W-1:0] LAST_ADR = ADDR_W'(RAM_DEPTH - 1);

  logic [TMR_W-1:0] timer;
  logic             hold_done;

  assign hold_done = (timer >= HOLD_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (!hold_done) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
      addr  <= '0;
    end else begin
      unique case (state)
        ST_START: state <= ST_CLEAR;
        ST_CLEAR: begin
          addr <= addr + 1'b1;
          if (addr == LAST_ADR) begin
            addr  <= '0;
            state <= ST_FUNC;
          end
        end
        ST_FUNC:  state <= ST_DISP;
        ST_DISP:  state <= ST_ENTRY;
        ST_ENTRY: state <= ST_BIAS;
        ST_BIAS:  state <= ST_DIR;
        ST_DIR:   state <= ST_WAIT;
        ST_WAIT:  if (hold_done) state <= ST_DONE;
        ST_DONE:  state <= ST_DONE;
        default:  state <= ST_START;
      endcase
    end
  end

  assign busy = (state != ST_DONE);
endmodule

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_por_pkg::*;
(
  input  logic [7:0] code,
  input  logic       ext,
  output cmd_hit_t   hit
);
  always_comb begin
    hit       = '0;
    hit.func  = (code[7:5] == 3'b001);
    hit.disp  = (code[7:3] == 5'b00001);
    hit.entry = !ext && (code[7:2] == 6'b000001);
    hit.bias  = ext && (code[7:4] == 4'b0001);
    hit.dir   = ext && (code[7:4] == 4'b0100);
  end
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_por_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_code,
  output cfg_t              cfg
);
  cmd_hit_t hit;
  logic     first_blank;

  lcd_cmd_decode u_dec (
    .code (wr_code),
    .ext  (cfg.ext_mode),
    .hit  (hit)
  );

  assign first_blank = (state == ST_CLEAR) && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (first_blank) cfg.entry_inc <= 1'b1;
      unique case (state)
        ST_FUNC: begin
          cfg.bus_8bit <= 1'b1;
          cfg.two_line <= 1'b1;
          cfg.ext_mode <= 1'b0;
        end
        ST_DISP: begin
          cfg.disp_on   <= 1'b0;
          cfg.cursor_on <= 1'b0;
          cfg.blink_on  <= 1'b0;
        end
        ST_ENTRY: begin
          cfg.entry_inc   <= 1'b1;
          cfg.entry_shift <= 1'b0;
        end
        ST_BIAS: cfg.bias_sel <= 2'b00;
        ST_DIR: begin
          cfg.com_rev <= 2'b00;
          cfg.seg_rev <= 2'b00;
        end
        ST_DONE: begin
          if (wr_en) begin
            if (hit.func) begin
              cfg.bus_8bit <= wr_code[4];
              cfg.two_line <= wr_code[3];
              cfg.ext_mode <= wr_code[2];
            end
            if (hit.disp) begin
              cfg.disp_on   <= wr_code[2];
              cfg.cursor_on <= wr_code[1];
              cfg.blink_on  <= wr_code[0];
            end
            if (hit.entry) begin
              cfg.entry_inc   <= wr_code[1];
              cfg.entry_shift <= wr_code[0];
            end
            if (hit.bias) cfg.bias_sel <= wr_code[3:2];
            if (hit.dir) begin
              cfg.com_rev <= wr_code[3:2];
              cfg.seg_rev <= wr_code[1:0];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_por_seq.sv
module lcd_por_seq
  import lcd_por_pkg::*;
#(
  parameter int CLK_HZ      = 50000000,
  parameter int HOLD_MS     = 40,
  parameter int RAM_DEPTH   = 80,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              hw_rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  output logic              busy,
  output logic              disp_on,
  output logic              cursor_on,
  output logic              blink_on,
  output logic              entry_inc,
  output logic              entry_shift,
  output logic              bus_8bit,
  output logic              two_line,
  output logic              ext_mode,
  output logic [1:0]        bias_sel,
  output logic [1:0]        com_rev,
  output logic [1:0]        seg_rev,
  output logic              clr_we,
  output logic [ADDR_W-1:0] clr_addr,
  output logic [7:0]        clr_data
);
  localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;

  logic              seq_arst_n, seq_rst_n, cfg_rst_n;
  seq_state_e        state;
  logic [ADDR_W-1:0] addr;
  cfg_t              cfg;

  assign seq_arst_n = pwr_good & hw_rst_n;

  lcd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_seq (
    .clk    (clk),
    .arst_n (seq_arst_n),
    .srst_n (seq_rst_n)
  );

  lcd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_cfg (
    .clk    (clk),
    .arst_n (pwr_good),
    .srst_n (cfg_rst_n)
  );

  lcd_por_fsm #(.HOLD_CYC(HOLD_CYC), .RAM_DEPTH(RAM_DEPTH)) u_fsm (
    .clk   (clk),
    .rst_n (seq_rst_n),
    .state (state),
    .addr  (addr),
    .busy  (busy)
  );

  assign cmd_ready = !busy;

  lcd_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (cfg_rst_n),
    .state   (state),
    .addr    (addr),
    .wr_en   (cmd_valid && cmd_ready),
    .wr_code (cmd_code),
    .cfg     (cfg)
  );

  assign clr_we   = (state == ST_CLEAR);
  assign clr_addr = addr;
  assign clr_data = BLANK_CODE;

  assign disp_on     = cfg.disp_on;
  assign cursor_on   = cfg.cursor_on;
  assign blink_on    = cfg.blink_on;
  assign entry_inc   = cfg.entry_inc;
  assign entry_shift = cfg.entry_shift;
  assign bus_8bit    = cfg.bus_8bit;
  assign two_line    = cfg.two_line;
  assign ext_mode    = cfg.ext_mode;
  assign bias_sel    = cfg.bias_sel;
  assign com_rev     = cfg.com_rev;
  assign seg_rev     = cfg.seg_rev;
endmodule

// File: rtl/lcd_por_seq_chk.sv
module lcd_por_seq_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              pwr_good,
  input logic              hw_rst_n,
  input logic              busy,
  input logic              cmd_ready,
  input logic              disp_on,
  input logic              cursor_on,
  input logic              blink_on,
  input logic              entry_inc,
  input logic              entry_shift,
  input logic              bus_8bit,
  input logic              two_line,
  input logic              ext_mode,
  input logic [1:0]        bias_sel,
  input logic [1:0]        com_rev,
  input logic [1:0]        seg_rev,
  input logic              clr_we,
  input logic [ADDR_W-1:0] clr_addr,
  input logic [7:0]        clr_data
);
  AST_BUSY_IN_RESET: assert property (@(posedge clk) disable iff (!pwr_good)
    !hw_rst_n |-> (busy && !cmd_ready)); // R1

  AST_BLANK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!pwr_good)
    clr_we |-> (busy && clr_data == 8'h20)); // R4

  AST_BLANK_ADDR_STEP: assert property (@(posedge clk) disable iff (!pwr_good)
    (clr_we && $past(clr_we)) |-> (clr_addr == $past(clr_addr) + 1'b1)); // R4

  AST_DEFAULTS_AT_END: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(busy) |-> (bus_8bit && two_line && !ext_mode && !disp_on && !cursor_on
                     && !blink_on && entry_inc && !entry_shift && bias_sel == 2'b00
                     && com_rev == 2'b00 && seg_rev == 2'b00)); // R6
endmodule

bind lcd_por_seq lcd_por_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .pwr_good    (pwr_good),
  .hw_rst_n    (hw_rst_n),
  .busy        (busy),
  .cmd_ready   (cmd_ready),
  .disp_on     (disp_on),
  .cursor_on   (cursor_on),
  .blink_on    (blink_on),
  .entry_inc   (entry_inc),
  .entry_shift (entry_shift),
  .bus_8bit    (bus_8bit),
  .two_line    (two_line),
  .ext_mode    (ext_mode),
  .bias_sel    (bias_sel),
  .com_rev     (com_rev),
  .seg_rev     (seg_rev),
  .clr_we      (clr_we),
  .clr_addr    (clr_addr),
  .clr_data    (clr_data)
);

// File: tb/lcd_por_seq_tb.sv
module lcd_por_seq_tb;
  localparam int CLK_HZ = 100000;
  localparam int HOLD   = (CLK_HZ / 1000) * 40;
  localparam int DEPTH  = 80;
  localparam logic [13:0] DEF_CFG = 14'b000_10_110_00_00_00;

  // {code, expected {disp,cur,blink,inc,shift,dl,n,ext,bias,com,seg}}
  localparam logic [21:0] VEC [13] = '{
    {8'h0E, 14'b110_10_110_00_00_00},
    {8'h07, 14'b110_11_110_00_00_00},
    {8'h1C, 14'b110_11_110_00_00_00},
    {8'h2C, 14'b110_11_011_00_00_00},
    {8'h14, 14'b110_11_011_01_00_00},
    {8'h4A, 14'b110_11_011_01_10_10},
    {8'h05, 14'b110_11_011_01_10_10},
    {8'h30, 14'b110_11_100_01_10_10},
    {8'h04, 14'b110_00_100_01_10_10},
    {8'h09, 14'b001_00_100_01_10_10},
    {8'h4F, 14'b001_00_100_01_10_10},
    {8'h05, 14'b001_01_100_01_10_10},
    {8'h0E, 14'b110_01_100_01_10_10}
  };

  logic clk = 1'b0;
  logic pwr_good = 1'b0, hw_rst_n = 1'b1, cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic cmd_ready, busy, disp_on, cursor_on, blink_on, entry_inc, entry_shift;
  logic bus_8bit, two_line, ext_mode, clr_we;
  logic [1:0] bias_sel, com_rev, seg_rev;
  logic [6:0] clr_addr;
  logic [7:0] clr_data;
  logic [13:0] cfg_v;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int fall_k, clr_n, clr_bad, last_clr, t_func, t_disp, t_entry, t_bias, t_dir;
  bit busy_at_hold, ready_seen, inject;

  always #10 clk = ~clk;

  assign cfg_v = {disp_on, cursor_on, blink_on, entry_inc, entry_shift, bus_8bit,
                  two_line, ext_mode, bias_sel, com_rev, seg_rev};

  lcd_por_seq #(.CLK_HZ(CLK_HZ), .HOLD_MS(40), .RAM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .pwr_good(pwr_good), .hw_rst_n(hw_rst_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .busy(busy), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .entry_inc(entry_inc),
    .entry_shift(entry_shift), .bus_8bit(bus_8bit), .two_line(two_line),
    .ext_mode(ext_mode), .bias_sel(bias_sel), .com_rev(com_rev), .seg_rev(seg_rev),
    .clr_we(clr_we), .clr_addr(clr_addr), .clr_data(clr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watch a sequence from the release edge; record timings seen at the ports.
  task automatic watch_seq(input int limit);
    fall_k = -1; clr_n = 0; clr_bad = 0; last_clr = -1;
    t_func = -1; t_disp = -1; t_entry = -1; t_bias = -1; t_dir = -1;
    busy_at_hold = 0; ready_seen = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (inject && k >= 100 && k < 105) begin
        cmd_valid = 1'b1; cmd_code = 8'h0F;
      end else if (inject && k == 105) begin
        cmd_valid = 1'b0;
      end
      if (inject && k >= 100 && k < 106 && cmd_ready) ready_seen = 1;
      if (clr_we) begin
        if (clr_addr != 7'(clr_n) || clr_data != 8'h20) clr_bad++;
        clr_n++; last_clr = k;
      end
      if (t_func  < 0 && bus_8bit && two_line && !ext_mode) t_func = k;
      if (t_disp  < 0 && !disp_on && !cursor_on && !blink_on) t_disp = k;
      if (t_entry < 0 && !entry_shift) t_entry = k;
      if (t_bias  < 0 && bias_sel == 2'b00) t_bias = k;
      if (t_dir   < 0 && com_rev == 2'b00 && seg_rev == 2'b00) t_dir = k;
      if (k == HOLD) busy_at_hold = busy;
      if (fall_k < 0 && !busy) fall_k = k;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    inject = 0;
    wait_neg(3);
    chk(busy && !cmd_ready, "R1 power low busy", busy, 1);
    chk(cfg_v == 14'd0, "R7 power low cfg cleared", cfg_v, 0);

    pwr_good = 1'b1;
    watch_seq(HOLD + 8);
    chk(busy_at_hold, "R2 busy held for hold time", busy_at_hold, 1);
    chk(fall_k > HOLD && fall_k <= HOLD + 4, "R2 busy fall window", fall_k, HOLD + 3);
    chk(clr_n == DEPTH, "R4 blanking write count", clr_n, DEPTH);
    chk(clr_bad == 0, "R4 blanking address/data", clr_bad, 0);
    chk(cfg_v == DEF_CFG, "R6 power-up defaults", cfg_v, DEF_CFG);
    chk(cmd_ready, "R2 ready after busy", cmd_ready, 1);

    // R9 / R10 table walk
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = VEC[i][21:14];
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(cfg_v == VEC[i][13:0], (i == 2 || i == 6 || i == 10) ? "R10 gated code" : "R9 decode",
          cfg_v, VEC[i][13:0]);
    end

    // R7 / R5 / R8: hardware reset keeps config, then ordered overwrite
    hw_rst_n = 1'b0;
    wait_neg(3);
    chk(busy && !cmd_ready, "R1 hw reset busy", busy, 1);
    chk(cfg_v == 14'b110_01_100_01_10_10, "R7 hw reset keeps cfg", cfg_v, 14'b110_01_100_01_10_10);
    hw_rst_n = 1'b1;
    inject = 1;
    watch_seq(HOLD + 8);
    inject = 0;
    chk(last_clr >= 0 && t_func > last_clr, "R5 func after blank", t_func, last_clr + 1);
    chk(t_disp > t_func, "R5 display after func", t_disp, t_func + 1);
    chk(t_entry > t_disp, "R5 entry after display", t_entry, t_disp + 1);
    chk(t_bias > t_entry, "R5 bias after entry", t_bias, t_entry + 1);
    chk(t_dir > t_bias, "R5 dir after bias", t_dir, t_bias + 1);
    chk(!ready_seen, "R8 no ready while busy", ready_seen, 0);
    chk(cfg_v == DEF_CFG, "R8 busy write ignored / R6 defaults", cfg_v, DEF_CFG);
    chk(clr_n == DEPTH, "R4 blank count after hw reset", clr_n, DEPTH);

    // R3 restart mid-sequence
    hw_rst_n = 1'b0;
    wait_neg(2);
    hw_rst_n = 1'b1;
    wait_neg(1000);
    chk(busy, "R3 busy mid sequence", busy, 1);
    hw_rst_n = 1'b0;
    wait_neg(2);
    hw_rst_n = 1'b1;
    watch_seq(HOLD + 8);
    chk(busy_at_hold, "R3 hold restarted", busy_at_hold, 1);
    chk(fall_k > HOLD && fall_k <= HOLD + 4, "R3 fall from second release", fall_k, HOLD + 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule